// File: doc/BRIEF.md
# Minicomputer Effective Address Unit

This block turns the 6-bit address field of an instruction into the 12-bit address the instruction acts on. The caller decodes the instruction and supplies an addressing mode, the field, and a jump flag. The unit then works out one of three things: an operand address, a jump target, or a small immediate operand. Every address the unit forms is placed in its storage address register, which drives the memory address port.

For the two pointer modes, the unit fetches one word from a 4096-word store through a request/valid handshake. It holds busy high until that word arrives. The unit also owns the program counter. When an instruction completes, the counter moves to the next word, or to the jump target if the instruction is a jump.

Relative addresses use the address of the instruction itself. All address arithmetic wraps modulo 4096.

Top module: `ea_unit`

## Requirements
- R1: With mode code 0 (page-zero), `done` rises one cycle after the accepting edge. `result` is the field zero-extended to 12 bits, and `mem_addr` equals `result`. `result_kind` is 1 (jump) when `is_jump` is set and 0 (operand) otherwise.
- R2: With mode code 1 (pointer in page zero), the unit raises `busy` and `mem_req` with `mem_addr` set to the zero-extended field. One cycle after the edge that sees `mem_valid`, `done` rises and `result` and `mem_addr` both equal `mem_rdata`.
- R3: With mode code 2 (forward), `result` is the instruction address plus the field, modulo 4096.
- R4: With mode code 3 (backward), `result` is the instruction address minus the field, modulo 4096. A field of zero yields the instruction address.
- R5: With mode code 4, and with the unused codes 6 and 7, `result` is the field with the upper six bits zero and `result_kind` is 2 (immediate). `mem_addr` keeps its previous value and `is_jump` has no effect.
- R6: With mode code 5 (pointer near P), the pointer location is the instruction address plus the field, and `result` is the word read from that location.
- R7: On completion, `pc` becomes the jump target when `result_kind` is 1. Otherwise it becomes the instruction address plus one, modulo 4096.
- R8: `start` is ignored while `busy` is high, and no second completion follows.
- R9: During reset, `pc`, `mem_addr`, `busy`, `mem_req` and `done` are all zero.
- R10: While `mem_req` is high and `mem_valid` is low, `mem_req` stays high and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address formation for one instruction |
| mode | input | 3 | Addressing mode code |
| e_field | input | 6 | Address field of the instruction |
| is_jump | input | 1 | Instruction is a jump |
| mem_rdata | input | 12 | Word returned by the store |
| mem_valid | input | 1 | `mem_rdata` is valid this cycle |
| mem_req | output | 1 | Read request to the store |
| mem_addr | output | 12 | Storage address register |
| busy | output | 1 | A pointer read is outstanding |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Final address or immediate operand |
| result_kind | output | 2 | 0 operand address, 1 jump target, 2 immediate |
| pc | output | 12 | Program counter |

## Verification
For the page-zero, forward, backward and immediate modes, `result`, `result_kind`, `mem_addr` and `pc` are updated on the edge that accepts `start`. For the two pointer modes, the pointer appears on `mem_addr` one edge after acceptance. The final address and the new `pc` follow one edge after the edge that samples `mem_valid`. The bench changes inputs on falling edges and reads outputs on the falling edge after the edge in question. This places each check exactly one register stage after its cause, and it also checks `mem_addr` at every falling edge of a stalled read.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 12;
  localparam int EFLD_W = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [EFLD_W-1:0] efld_t;

  typedef enum logic [2:0] {
    M_PAGE0   = 3'd0,
    M_PTR0    = 3'd1,
    M_FWD     = 3'd2,
    M_BACK    = 3'd3,
    M_IMMED   = 3'd4,
    M_PTR_REL = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    K_OPERAND = 2'd0,
    K_JUMP    = 2'd1,
    K_IMMED   = 2'd2
  } rkind_e;

  function automatic addr_t zext_e(input efld_t e);
    return {{(ADDR_W-EFLD_W){1'b0}}, e};
  endfunction

  function automatic addr_t wrap_add(input addr_t p, input efld_t e);
    return p + zext_e(e);
  endfunction

  function automatic addr_t wrap_sub(input addr_t p, input efld_t e);
    return p - zext_e(e);
  endfunction

  function automatic addr_t step_one(input addr_t p);
    return p + addr_t'(1);
  endfunction
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  logic [2:0] mode_i,
  input  efld_t      efld_i,
  input  addr_t      pc_i,
  input  logic       jump_i,
  output addr_t      addr_o,
  output logic       read_o,
  output rkind_e     kind_o
);
  rkind_e addr_kind;

  assign addr_kind = jump_i ? K_JUMP : K_OPERAND;

  always_comb begin
    addr_o = zext_e(efld_i);
    read_o = 1'b0;
    kind_o = addr_kind;
    case (mode_i)
      M_PAGE0:   addr_o = zext_e(efld_i);
      M_PTR0: begin
        addr_o = zext_e(efld_i);
        read_o = 1'b1;
      end
      M_FWD:     addr_o = wrap_add(pc_i, efld_i);
      M_BACK:    addr_o = wrap_sub(pc_i, efld_i);
      M_PTR_REL: begin
        addr_o = wrap_add(pc_i, efld_i);
        read_o = 1'b1;
      end
      default: begin
        addr_o = zext_e(efld_i);
        kind_o = K_IMMED;
      end
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic read_i,
  input  logic mem_valid_i,
  output logic busy_o,
  output logic mem_req_o,
  output logic accept_o,
  output logic fin_now_o,
  output logic fin_mem_o
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st_q;

  assign busy_o    = (st_q == S_WAIT);
  assign mem_req_o = (st_q == S_WAIT);
  assign accept_o  = start_i && (st_q == S_IDLE);
  assign fin_now_o = accept_o && !read_i;
  assign fin_mem_o = (st_q == S_WAIT) && mem_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (accept_o && read_i) st_q <= S_WAIT;
        S_WAIT: if (mem_valid_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_pc.sv
module ea_pc
  import ea_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_i,
  input  logic  load_i,
  input  addr_t target_i,
  input  addr_t base_i,
  output addr_t pc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o <= RESET_PC;
    end else if (upd_i) begin
      pc_o <= load_i ? target_i : step_one(base_i);
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [EFLD_W-1:0] e_field,
  input  logic              is_jump,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] result,
  output logic [1:0]        result_kind,
  output logic [ADDR_W-1:0] pc
);
  // named internal events
  logic   accept, fin_now, fin_mem, complete;
  addr_t  calc_addr, cmp_target, instr_pc, s_q, res_q, pc_w;
  logic   calc_read;
  rkind_e calc_kind, pend_kind, cmp_kind, kind_q;
  logic   done_q;

  ea_calc u_calc (
    .mode_i (mode),
    .efld_i (e_field),
    .pc_i   (pc_w),
    .jump_i (is_jump),
    .addr_o (calc_addr),
    .read_o (calc_read),
    .kind_o (calc_kind)
  );

  ea_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .read_i      (calc_read),
    .mem_valid_i (mem_valid),
    .busy_o      (busy),
    .mem_req_o   (mem_req),
    .accept_o    (accept),
    .fin_now_o   (fin_now),
    .fin_mem_o   (fin_mem)
  );

  assign complete   = fin_now || fin_mem;
  assign cmp_kind   = fin_mem ? pend_kind : calc_kind;
  assign cmp_target = fin_mem ? mem_rdata : calc_addr;

  ea_pc #(.RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (complete),
    .load_i   (cmp_kind == K_JUMP),
    .target_i (cmp_target),
    .base_i   (fin_mem ? instr_pc : pc_w),
    .pc_o     (pc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q       <= '0;
      res_q     <= '0;
      kind_q    <= K_OPERAND;
      pend_kind <= K_OPERAND;
      instr_pc  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= complete;
      if (accept) begin
        instr_pc  <= pc_w;
        pend_kind <= calc_kind;
      end
      if (accept && calc_read) begin
        s_q <= calc_addr;
      end else if (complete && cmp_kind != K_IMMED) begin
        s_q <= cmp_target;
      end
      if (complete) begin
        res_q  <= cmp_target;
        kind_q <= cmp_kind;
      end
    end
  end

  assign mem_addr    = s_q;
  assign done        = done_q;
  assign result      = res_q;
  assign result_kind = kind_q;
  assign pc          = pc_w;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        mode,
  input logic [EFLD_W-1:0] e_field,
  input logic              mem_valid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] result,
  input logic [1:0]        result_kind,
  input logic [ADDR_W-1:0] pc,
  input logic              accept,
  input logic [ADDR_W-1:0] instr_pc
);
  a_r1_page0: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode == M_PAGE0 |=> done && result == zext_e($past(e_field)) && mem_addr == result);

  a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r4_back: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode == M_BACK |=> result == wrap_sub($past(pc), $past(e_field)));

  a_r5_imm_upper: assert property (@(posedge clk) disable iff (!rst_n)
    done && result_kind == K_IMMED |-> result[ADDR_W-1:EFLD_W] == '0);

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    done && result_kind != K_JUMP |-> pc == step_one(instr_pc));

  a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
    done && result_kind == K_JUMP |-> pc == result);

  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !mem_valid |=> busy && !done && $stable(instr_pc));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
endmodule

bind ea_unit ea_unit_chk u_chk (.*);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [5:0]  e_field = 6'd0;
  logic        is_jump = 1'b0;
  logic [11:0] mem_rdata = 12'd0;
  logic        mem_valid = 1'b0;
  logic        mem_req, busy, done;
  logic [11:0] mem_addr, result, pc;
  logic [1:0]  result_kind;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [11:0] mpc = 12'd0;
  logic [11:0] ms = 12'd0;

  always #2.5 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .e_field(e_field),
    .is_jump(is_jump), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy), .done(done),
    .result(result), .result_kind(result_kind), .pc(pc)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 50000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic logic [11:0] mem_fn(input logic [11:0] a);
    return 12'(a * 12'd5 + 12'h123);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "pc", pc, 0);
    chk("R9", "mem_addr", mem_addr, 0);
    chk("R9", "busy", busy, 0);
    chk("R9", "mem_req", mem_req, 0);
    chk("R9", "done", done, 0);
    rst_n = 1'b1;
    mpc = 12'd0;
    ms = 12'd0;
  endtask

  task automatic run_instr(input logic [2:0] m, input logic [5:0] e, input logic j,
                           input int lat, input string tag);
    logic [11:0] cur, ptr, tgt, ez;
    logic        rd;
    int          kind;
    cur  = mpc;
    ez   = {6'd0, e};
    rd   = (m == 3'd1) || (m == 3'd5);
    kind = j ? 1 : 0;
    ptr  = 12'd0;
    case (m)
      3'd0: tgt = ez;
      3'd1: ptr = ez;
      3'd2: tgt = 12'(cur + ez);
      3'd3: tgt = 12'(cur - ez);
      3'd5: ptr = 12'(cur + ez);
      default: begin tgt = ez; kind = 2; end
    endcase
    if (rd) tgt = mem_fn(ptr);
    @(negedge clk);
    start = 1'b1; mode = m; e_field = e; is_jump = j;
    @(negedge clk);
    start = 1'b0;
    if (rd) begin
      chk(tag, "busy", busy, 1);
      chk(tag, "pointer addr", mem_addr, ptr);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk("R10", "req held", mem_req, 1);
        chk("R10", "addr held", mem_addr, ptr);
      end
      mem_valid = 1'b1;
      mem_rdata = mem_fn(ptr);
      @(negedge clk);
      mem_valid = 1'b0;
    end
    chk(tag, "done", done, 1);
    chk(tag, "result", result, tgt);
    chk(tag, "kind", result_kind, kind);
    chk(tag, "busy off", busy, 0);
    if (kind != 2) ms = tgt;
    chk(tag, "mem_addr", mem_addr, ms);
    mpc = (kind == 1) ? tgt : 12'(cur + 12'd1);
    chk("R7", "pc", pc, mpc);
  endtask

  // packed vector: mode[11:9] jump[8] latency[7:6] field[5:0]
  localparam logic [11:0] VEC [16] = '{
    {3'd0, 1'b0, 2'd0, 6'd5},   // R1
    {3'd0, 1'b0, 2'd0, 6'd63},  // R1
    {3'd2, 1'b0, 2'd0, 6'd10},  // R3
    {3'd3, 1'b0, 2'd0, 6'd2},   // R4
    {3'd4, 1'b0, 2'd0, 6'd42},  // R5
    {3'd4, 1'b1, 2'd0, 6'd17},  // R5 jump flag ignored
    {3'd1, 1'b0, 2'd0, 6'd7},   // R2
    {3'd1, 1'b0, 2'd3, 6'd20},  // R2 R10
    {3'd0, 1'b1, 2'd0, 6'd30},  // R1 R7
    {3'd2, 1'b1, 2'd0, 6'd12},  // R3 R7
    {3'd3, 1'b1, 2'd0, 6'd5},   // R4 R7
    {3'd1, 1'b1, 2'd2, 6'd3},   // R2 R7
    {3'd5, 1'b1, 2'd1, 6'd4},   // R6
    {3'd5, 1'b0, 2'd0, 6'd9},   // R6
    {3'd6, 1'b0, 2'd0, 6'd11},  // R5 unused code
    {3'd3, 1'b0, 2'd0, 6'd0}    // R4 zero field
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd5: return "R6";
      default: return "R5";
    endcase
  endfunction

  initial begin
    logic [11:0] hold_ptr, cur;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      run_instr(VEC[i][11:9], VEC[i][5:0], VEC[i][8], int'(VEC[i][7:6]),
                tag_of(VEC[i][11:9]));
    end

    // wrap corners after a fresh reset
    do_reset();
    run_instr(3'd3, 6'd1, 1'b1, 0, "R4");   // P=0 back by 1 -> 4095
    chk("R4", "wrap target", pc, 4095);
    run_instr(3'd2, 6'd63, 1'b0, 0, "R3");  // 4095+63 wraps to 62
    chk("R3", "wrap result", result, 62);
    run_instr(3'd3, 6'd0, 1'b0, 0, "R4");   // field zero gives P itself
    chk("R4", "zero field", result, 0);

    // R8: start while busy is ignored
    cur = mpc;
    hold_ptr = 12'd9;
    @(negedge clk);
    start = 1'b1; mode = 3'd1; e_field = 6'd9; is_jump = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = 3'd0; e_field = 6'd33;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "no done while busy", done, 0);
    chk("R8", "pointer kept", mem_addr, hold_ptr);
    chk("R8", "still busy", busy, 1);
    mem_valid = 1'b1;
    mem_rdata = mem_fn(hold_ptr);
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R8", "result from pointer", result, mem_fn(hold_ptr));
    @(negedge clk);
    chk("R8", "single completion", done, 0);
    chk("R8", "pc once", pc, 12'(cur + 12'd1));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule